// File: doc/BRIEF.md
# Right-justified stereo serial audio receiver

This block takes a three-wire stereo audio stream (bit clock, serial data, word select) and turns it into a pair of parallel 16-bit two's-complement samples in the system clock domain. Each half-frame carries one channel, most significant bit first. The word is packed against the end of the half-frame, so its least significant bit is the last bit before word select changes level. Word select high marks the left channel and low marks the right channel.

The number of bit-clock periods in each half-frame may be anywhere from 16 to 32, and it may change from one half-frame to the next. The receiver keeps whatever 16 bits arrived last before each word-select change and drops the bits in front of them. At the start of each new frame the two words of the frame just completed cross into the system clock domain together. A one-cycle strobe marks their arrival. The bit clock may have any phase relative to the system clock.

Top module: `rj_audio_rx`

## Requirements
- R1: While `rst_n` is low at system clock edges, `left_o` and `right_o` are cleared to zero and `valid_o` stays low. Bit-clock-side state is cleared by `rst_n` being low at bit clock rising edges.
- R2: `sdata_i` and `wsel_i` are sampled on rising edges of `sck_i`. A half-frame ends at the first rising edge where `wsel_i` differs from its level at the previous edge. The left word equals the last 16 data bits sampled while `wsel_i` was high, with the first of those 16 bits as bit 15.
- R3: The right word equals the last 16 data bits sampled while `wsel_i` was low, with the first of those 16 bits as bit 15.
- R4: Any bits in a half-frame ahead of its last 16 have no effect on the output, whatever their values. Half-frames of 16 to 32 bits are accepted.
- R5: The number of bits per half-frame may differ between half-frames and between frames, with no resynchronisation step.
- R6: Each low-to-high change of `wsel_i` that completes a right word gives exactly one `valid_o` pulse, one system clock cycle wide. In that cycle both words of the frame appear on `left_o` and `right_o`. Between pulses, both outputs hold their values.
- R7: After reset, a completed right word produces no strobe unless a left word has been completed first.
- R8: Samples pass through bit-exact, including 0x8000, 0x7FFF, 0xFFFF and 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck_i | input | 1 | Serial bit clock |
| sdata_i | input | 1 | Serial data, MSB first |
| wsel_i | input | 1 | Word select, high for left, low for right |
| left_o | output | 16 | Left sample of the last complete frame |
| right_o | output | 16 | Right sample of the last complete frame |
| valid_o | output | 1 | One-cycle strobe when a new pair is presented |

## Verification
The hardest case to reach is a right word that completes before any left word has been captured since reset. It only arises when the stream is already partway through a right half-frame as reset is released. The bench reaches it by releasing reset with word select low and clocking a few right-channel bits. It then sends a full left half-frame and confirms that no strobe appeared at that word-select rise. A second hard case is a frame that is complete on the data line but not yet closed by the next rising edge of word select. The bench holds the bit clock at that point and checks that the outputs keep their old values.

// File: rtl/rjrx_pkg.sv
package rjrx_pkg;

  localparam int SAMPLE_W = 16;
  localparam int PAIR_W   = 2 * SAMPLE_W;

  typedef logic [SAMPLE_W-1:0] sample_t;

  // What a bit clock edge means for the half-frame in progress.
  typedef enum logic [1:0] {
    EV_NONE       = 2'd0,
    EV_LEFT_DONE  = 2'd1,
    EV_RIGHT_DONE = 2'd2
  } ws_evt_e;

  // Newest bit enters at the bottom; the oldest falls off the top.
  function automatic sample_t shift_in(input sample_t cur, input logic bit_in);
    return {cur[SAMPLE_W-2:0], bit_in};
  endfunction

  // Classify an edge from the previous and present word-select levels.
  function automatic ws_evt_e ws_event(input logic primed, input logic ws_prev,
                                       input logic ws_now);
    if (!primed || (ws_prev == ws_now)) return EV_NONE;
    if (ws_prev) return EV_LEFT_DONE;
    return EV_RIGHT_DONE;
  endfunction

endpackage

// File: rtl/rjrx_shift.sv
module rjrx_shift
  import rjrx_pkg::*;
(
  input  logic    sck_i,
  input  logic    rst_n,
  input  logic    sdata_i,
  input  logic    wsel_i,
  output ws_evt_e evt_o,
  output sample_t pair_left_o,
  output sample_t pair_right_o,
  output logic    pair_tog_o
);

  sample_t sreg_q;
  sample_t left_hold_q;
  sample_t pair_l_q;
  sample_t pair_r_q;
  logic    ws_q;
  logic    primed_q;
  logic    left_ok_q;
  logic    tog_q;
  ws_evt_e evt;

  assign evt = ws_event(primed_q, ws_q, wsel_i);

  always_ff @(posedge sck_i) begin
    if (!rst_n) begin
      sreg_q      <= '0;
      left_hold_q <= '0;
      pair_l_q    <= '0;
      pair_r_q    <= '0;
      ws_q        <= 1'b0;
      primed_q    <= 1'b0;
      left_ok_q   <= 1'b0;
      tog_q       <= 1'b0;
    end else begin
      primed_q <= 1'b1;
      ws_q     <= wsel_i;
      sreg_q   <= shift_in(sreg_q, sdata_i);
      case (evt)
        EV_LEFT_DONE: begin
          left_hold_q <= sreg_q;
          left_ok_q   <= 1'b1;
        end
        EV_RIGHT_DONE: begin
          if (left_ok_q) begin
            pair_l_q <= left_hold_q;
            pair_r_q <= sreg_q;
            tog_q    <= ~tog_q;
          end
        end
        default: ;
      endcase
    end
  end

  assign evt_o        = evt;
  assign pair_left_o  = pair_l_q;
  assign pair_right_o = pair_r_q;
  assign pair_tog_o   = tog_q;

endmodule

// File: rtl/rjrx_cdc.sv
module rjrx_cdc
  import rjrx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tog_i,
  input  sample_t pair_left_i,
  input  sample_t pair_right_i,
  output sample_t left_o,
  output sample_t right_o,
  output logic    valid_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   last_q;
  logic                   pair_arrived;
  sample_t                left_q;
  sample_t                right_q;
  logic                   valid_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      assign sync_d = tog_i;
    end else begin : g_chain
      assign sync_d = {sync_q[SYNC_STAGES-2:0], tog_i};
    end
  endgenerate

  assign pair_arrived = sync_q[SYNC_STAGES-1] ^ last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q  <= '0;
      last_q  <= 1'b0;
      left_q  <= '0;
      right_q <= '0;
      valid_q <= 1'b0;
    end else begin
      sync_q  <= sync_d;
      last_q  <= sync_q[SYNC_STAGES-1];
      valid_q <= pair_arrived;
      if (pair_arrived) begin
        left_q  <= pair_left_i;
        right_q <= pair_right_i;
      end
    end
  end

  assign left_o  = left_q;
  assign right_o = right_q;
  assign valid_o = valid_q;

endmodule

// File: rtl/rj_audio_rx.sv
module rj_audio_rx
  import rjrx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sck_i,
  input  logic                sdata_i,
  input  logic                wsel_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o
);

  ws_evt_e shift_evt;
  sample_t pair_left;
  sample_t pair_right;
  logic    pair_tog;

  rjrx_shift u_shift (
    .sck_i        (sck_i),
    .rst_n        (rst_n),
    .sdata_i      (sdata_i),
    .wsel_i       (wsel_i),
    .evt_o        (shift_evt),
    .pair_left_o  (pair_left),
    .pair_right_o (pair_right),
    .pair_tog_o   (pair_tog)
  );

  rjrx_cdc #(.SYNC_STAGES(SYNC_STAGES)) u_cdc (
    .clk          (clk),
    .rst_n        (rst_n),
    .tog_i        (pair_tog),
    .pair_left_i  (pair_left),
    .pair_right_i (pair_right),
    .left_o       (left_o),
    .right_o      (right_o),
    .valid_o      (valid_o)
  );

endmodule

// File: rtl/rj_audio_rx_chk.sv
module rj_audio_rx_chk
  import rjrx_pkg::*;
(
  input logic    clk,
  input logic    rst_n,
  input logic    sck_i,
  input ws_evt_e shift_evt,
  input sample_t pair_left,
  input sample_t pair_right,
  input logic    pair_tog,
  input sample_t left_o,
  input sample_t right_o,
  input logic    valid_o
);

  // Checker-side record of whether a left word has completed since reset.
  logic seen_left_q;
  always_ff @(posedge sck_i) begin
    if (!rst_n) seen_left_q <= 1'b0;
    else if (shift_evt == EV_LEFT_DONE) seen_left_q <= 1'b1;
  end

  // R6: strobe is one system cycle wide
  p_strobe_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  // R6: outputs only move in the strobe cycle
  p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(left_o) && $stable(right_o)));

  // R6: a closed frame with a left word flips the handshake
  p_frame_toggle_r6: assert property (@(posedge sck_i) disable iff (!rst_n)
    (shift_evt == EV_RIGHT_DONE && seen_left_q) |=> !$stable(pair_tog));

  // R7: no handshake for a right word without a prior left word
  p_no_orphan_right_r7: assert property (@(posedge sck_i) disable iff (!rst_n)
    (shift_evt == EV_RIGHT_DONE && !seen_left_q) |=> $stable(pair_tog));

  // R2: with no word-select change, the handed-over pair is untouched
  p_pair_quiet_r2: assert property (@(posedge sck_i) disable iff (!rst_n)
    (shift_evt == EV_NONE) |=>
      ($stable(pair_tog) && $stable(pair_left) && $stable(pair_right)));

endmodule

bind rj_audio_rx rj_audio_rx_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .sck_i      (sck_i),
  .shift_evt  (shift_evt),
  .pair_left  (pair_left),
  .pair_right (pair_right),
  .pair_tog   (pair_tog),
  .left_o     (left_o),
  .right_o    (right_o),
  .valid_o    (valid_o)
);

// File: tb/rj_audio_rx_tb_top.sv
`timescale 1ns/100ps
module rj_audio_rx_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sck = 1'b0;
  logic        sdata = 1'b0;
  logic        wsel = 1'b0;
  logic [15:0] left_o;
  logic [15:0] right_o;
  logic        valid_o;

  int total = 0;
  int bad = 0;
  int n_valid = 0;
  int exp_valid = 0;
  logic prev_valid = 1'b0;
  logic [15:0] exp_l = '0;
  logic [15:0] exp_r = '0;

  always #2.5 clk = ~clk;

  rj_audio_rx dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .sck_i   (sck),
    .sdata_i (sdata),
    .wsel_i  (wsel),
    .left_o  (left_o),
    .right_o (right_o),
    .valid_o (valid_o)
  );

  // {left, right, bits in left half, bits in right half, leading fill bit}
  localparam int NVEC = 8;
  localparam logic [44:0] VEC [NVEC] = '{
    {16'h1234, 16'hABCD, 6'd16, 6'd16, 1'b0},
    {16'h8000, 16'h7FFF, 6'd32, 6'd32, 1'b1},  // R8 extremes, R4 long halves
    {16'h7FFF, 16'h8000, 6'd24, 6'd20, 1'b1},  // R5 uneven halves
    {16'hFFFF, 16'h0001, 6'd17, 6'd31, 1'b0},
    {16'h0000, 16'hFFFF, 6'd32, 6'd16, 1'b1},  // R4 ones ahead of a zero word
    {16'hA5A5, 16'h5A5A, 6'd16, 6'd32, 1'b0},
    {16'h0001, 16'h8001, 6'd20, 6'd20, 1'b1},
    {16'hC3C3, 16'h3C3C, 6'd29, 6'd18, 1'b0}
  };

  // Strobe monitor, sampled away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_valid) begin
        total++;
        if (valid_o) begin
          bad++;
          $display("FAIL R6 strobe width: valid still high, got=1 exp=0");
        end
      end
      if (valid_o) n_valid++;
    end
    prev_valid = valid_o;
  end

  task automatic check16(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic check_int(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic drive_bit(input logic ws, input logic d);
    sck = 1'b0;
    wsel = ws;
    sdata = d;
    #80;
    sck = 1'b1;
    #80;
  endtask

  task automatic send_half(input logic ws, input logic [15:0] w, input int n, input logic fill);
    for (int i = 0; i < n; i++) begin
      if (i < n - 16) drive_bit(ws, fill);
      else drive_bit(ws, w[15 - (i - (n - 16))]);
    end
  endtask

  // First edge of the next left half closes the frame.
  task automatic kick(input logic fill);
    drive_bit(1'b1, fill);
    #100;
  endtask

  task automatic apply_reset(input logic ws);
    rst_n = 1'b0;
    for (int i = 0; i < 4; i++) drive_bit(ws, 1'b0);
    #100;
    rst_n = 1'b1;
  endtask

  task automatic check_pair(input string tag);
    check16({"R2 R4 R5 R8 left ", tag}, left_o, exp_l);
    check16({"R3 R4 R5 R8 right ", tag}, right_o, exp_r);
    check_int({"R6 strobe count ", tag}, n_valid, exp_valid);
  endtask

  initial begin
    #800000;
    bad++;
    total++;
    $display("FAIL watchdog: run hung, got=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state; word select low so the stream starts mid right half
    apply_reset(1'b0);
    #20;
    check16("R1 left after reset", left_o, 16'h0000);
    check16("R1 right after reset", right_o, 16'h0000);
    check_int("R1 no strobe in reset", n_valid, 0);

    // R7: partial right half, then a left half: no strobe at the rise
    for (int i = 0; i < 5; i++) drive_bit(1'b0, 1'b1);
    send_half(1'b1, 16'h4C1D, 16, 1'b0);
    #200;
    check_int("R7 orphan right word gave no strobe", n_valid, 0);
    send_half(1'b0, 16'hB00F, 16, 1'b1);
    kick(1'b0);
    exp_l = 16'h4C1D; exp_r = 16'hB00F; exp_valid = 1;
    check_pair("first frame");

    // Table of frames
    for (int v = 0; v < NVEC; v++) begin
      send_half(1'b1, VEC[v][44:29], int'(VEC[v][12:7]), VEC[v][0]);
      send_half(1'b0, VEC[v][28:13], int'(VEC[v][6:1]), VEC[v][0]);
      kick(~VEC[v][0]);
      exp_l = VEC[v][44:29]; exp_r = VEC[v][28:13]; exp_valid++;
      check_pair($sformatf("vec%0d", v));
    end

    // R6: frame complete on the wire but not closed: outputs hold
    send_half(1'b1, 16'h1111, 16, 1'b0);
    send_half(1'b0, 16'h2222, 24, 1'b1);
    #300;
    check_pair("R6 held before close");
    kick(1'b0);
    exp_l = 16'h1111; exp_r = 16'h2222; exp_valid++;
    check_pair("after close");

    // R1: reset mid stream clears outputs, no strobe
    apply_reset(1'b1);
    #20;
    check16("R1 left after mid reset", left_o, 16'h0000);
    check16("R1 right after mid reset", right_o, 16'h0000);
    check_int("R1 no strobe from reset", n_valid, exp_valid);

    // Operation resumes after reset
    send_half(1'b1, 16'h6E6E, 20, 1'b1);
    send_half(1'b0, 16'h9191, 16, 1'b0);
    kick(1'b1);
    exp_l = 16'h6E6E; exp_r = 16'h9191; exp_valid++;
    check_pair("after reset");

    #100;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule